// File: doc/BRIEF.md
# Parallel-to-Serial Pin Reduction Master

This block lets two chips exchange a parallel word over four wires instead of a wide bus. When a frame starts, it captures the low bits of a parallel input word. It shifts them out most significant bit first on a serial data line, framed by an active-low select and a clock it generates itself. At the same time it collects the bits that come back on the serial input. When the frame ends, it presents the collected bits as a parallel output word.

The frame length can be set from 4 to 16 bits. The serial clock rate is the system clock divided by an even divisor. A 2-bit configuration field switches the unit on: it works only when that field holds binary 01. A 2-bit start selector picks the event that opens a frame:
- free-running back-to-back frames,
- a change of the input word,
- a rising edge on a trigger pin,
- a trigger edge that only counts when the input word has also changed.

Top module: `pinred_master`

## Requirements
- R1: The number of bits in a frame is the programmed length clamped to the range 4..16. A value below 4 gives 4 bits and a value above 16 gives 16 bits.
- R2: While the configuration field `cfg_sel` is anything other than 2'b01, no frame starts, `cs_n` stays high and `sck` stays low, whatever the other inputs do.
- R3: With start selector 2'b00 (free-running), a new frame begins with exactly one clock cycle of `cs_n` high between frames.
- R4: With start selector 2'b01 (data change), a frame begins when the low frame-length bits of `par_in` differ from the word last transmitted. An equal value starts nothing, even if the bits above the frame length differ. The stored word is zero after reset.
- R5: With start selector 2'b10 (trigger), a rising edge on `trig_in` seen while idle starts exactly one frame. Holding `trig_in` high, or an edge that arrives during a frame, starts nothing more.
- R6: With start selector 2'b11 (trigger and change), a trigger edge starts a frame only if the masked input differs from the word last transmitted. Neither a trigger alone nor a change alone starts one.
- R7: `sout` carries the low frame-length bits of the captured input, most significant first. `sout` changes only when `cs_n` falls or `sck` falls. `sin` is taken when `sck` rises.
- R8: `par_out` takes the received word, with the bits above the frame length zero, in the cycle where `cs_n` returns high. At all other times it holds its value.
- R9: Each `sck` level lasts max(`clk_div`/2, 1) system clock cycles, rounding down. The first rising edge comes that many cycles after `cs_n` falls, and `sck` is low whenever `cs_n` is high.
- R10: `par_in` is captured when the frame starts. Changing it during the frame does not alter the bits sent.
- R11: After reset, `cs_n` is 1 and `sck`, `sout` and `par_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 2 | Unit is active only when 2'b01 |
| start_sel | input | 2 | Start condition: 00 free, 01 change, 10 trigger, 11 trigger and change |
| frame_len | input | 5 | Requested frame length in bits (clamped to 4..16) |
| clk_div | input | 8 | Serial clock divisor; each clock level lasts max(clk_div/2,1) cycles |
| par_in | input | 16 | Parallel word to send |
| trig_in | input | 1 | Trigger input, acted on at its rising edge |
| sin | input | 1 | Serial data from the far side |
| sck | output | 1 | Serial clock, low when idle |
| sout | output | 1 | Serial data to the far side |
| cs_n | output | 1 | Active-low frame select |
| par_out | output | 16 | Last received word |

## Verification
A bench model of the far-side device returns a known word on every frame and records what arrives on `sout`. Each frame is therefore checked both ways, for bit count, order and clock timing. Directed frames at lengths 2, 4, 16 and 20 and divisors 0, 3 and 10 separate correct clamping and rounding from off-by-one errors. A word changed during a frame shows whether the input was captured at the start. For each start condition, the bench applies patterns that should and should not start a frame:
- a held trigger,
- a trigger during a frame,
- an unchanged word,
- a word that differs only above the frame length,
- a change with no trigger.

Counting the frames that result tells the four start conditions apart. Randomised lengths, divisors and words in trigger mode then cover mixed settings.

// File: rtl/pinred_pkg.sv
package pinred_pkg;

    typedef enum logic [1:0] {
        SM_FREE       = 2'b00,
        SM_DELTA      = 2'b01,
        SM_TRIG       = 2'b10,
        SM_TRIG_DELTA = 2'b11
    } start_mode_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;

    localparam logic [1:0] CFG_SERIAL = 2'b01;
    localparam int         MIN_FRAME  = 4;

    // Clamp a requested frame length into the legal window.
    function automatic int clamp_frame(input int raw, input int max_w);
        if (raw < MIN_FRAME) return MIN_FRAME;
        if (raw > max_w)     return max_w;
        return raw;
    endfunction

    // Cycles per serial clock level for a given divisor.
    function automatic int half_of(input int div);
        int h;
        h = div / 2;
        return (h < 1) ? 1 : h;
    endfunction

endpackage

// File: rtl/pinred_start_ctl.sv
module pinred_start_ctl
    import pinred_pkg::*;
#(
    parameter int MAX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  start_mode_e      mode,
    input  logic [MAX_W-1:0] word,
    input  logic             trig,
    input  logic             idle,
    output logic             start
);

    logic             trig_q;
    logic [MAX_W-1:0] last_word;
    logic             trig_rise;
    logic             delta;
    logic             cond;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q    <= 1'b0;
            last_word <= '0;
        end else begin
            trig_q <= trig;
            if (start) last_word <= word;
        end
    end

    always_comb begin
        trig_rise = trig & ~trig_q;
        delta     = (word != last_word);
        unique case (mode)
            SM_FREE:       cond = 1'b1;
            SM_DELTA:      cond = delta;
            SM_TRIG:       cond = trig_rise;
            SM_TRIG_DELTA: cond = trig_rise & delta;
            default:       cond = 1'b0;
        endcase
        start = enable & idle & cond;
    end

endmodule

// File: rtl/pinred_sck_gen.sv
module pinred_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             sck,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [DIV_W-1:0] cnt;
    logic             wrap;

    always_comb begin
        wrap     = run && (cnt == half - DIV_W'(1));
        rise_evt = wrap & ~sck;
        fall_evt = wrap & sck;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/pinred_shift_core.sv
module pinred_shift_core
    import pinred_pkg::*;
#(
    parameter int MAX_W = 16,
    parameter int LEN_W = 5,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MAX_W-1:0] word,
    input  logic [LEN_W-1:0] len,
    input  logic [DIV_W-1:0] half_in,
    input  logic             rise_evt,
    input  logic             fall_evt,
    input  logic             sin,
    output logic             run,
    output logic             idle,
    output logic [DIV_W-1:0] half_q,
    output logic             cs_n,
    output logic             sout,
    output logic [MAX_W-1:0] par_out
);

    phase_e           phase;
    logic [MAX_W-1:0] tx_sh;
    logic [MAX_W-1:0] rx_sh;
    logic [MAX_W-1:0] aligned;
    logic [LEN_W-1:0] bits_left;

    // Move the first bit of the frame to the top of the shifter.
    always_comb begin
        aligned = word << (MAX_W - int'(len));
        run     = (phase == PH_SHIFT);
        idle    = (phase == PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            tx_sh     <= '0;
            rx_sh     <= '0;
            bits_left <= '0;
            half_q    <= DIV_W'(1);
            cs_n      <= 1'b1;
            sout      <= 1'b0;
            par_out   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_SHIFT;
                        cs_n      <= 1'b0;
                        sout      <= aligned[MAX_W-1];
                        tx_sh     <= aligned << 1;
                        rx_sh     <= '0;
                        bits_left <= len;
                        half_q    <= half_in;
                    end
                end
                PH_SHIFT: begin
                    if (rise_evt) begin
                        rx_sh     <= {rx_sh[MAX_W-2:0], sin};
                        bits_left <= bits_left - LEN_W'(1);
                    end else if (fall_evt) begin
                        if (bits_left == '0) begin
                            phase   <= PH_IDLE;
                            cs_n    <= 1'b1;
                            sout    <= 1'b0;
                            par_out <= rx_sh;
                        end else begin
                            sout  <= tx_sh[MAX_W-1];
                            tx_sh <= tx_sh << 1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pinred_master.sv
module pinred_master
    import pinred_pkg::*;
#(
    parameter  int MAX_W = 16,
    parameter  int DIV_W = 8,
    localparam int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_sel,
    input  logic [1:0]       start_sel,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [MAX_W-1:0] par_in,
    input  logic             trig_in,
    input  logic             sin,
    output logic             sck,
    output logic             sout,
    output logic             cs_n,
    output logic [MAX_W-1:0] par_out
);

    typedef struct packed {
        logic             en;
        logic [LEN_W-1:0] len;
        logic [DIV_W-1:0] half;
    } frame_cfg_t;

    frame_cfg_t       cfg;
    logic [MAX_W-1:0] word_m;
    logic             start;
    logic             idle;
    logic             run;
    logic             rise_evt;
    logic             fall_evt;
    logic [DIV_W-1:0] half_q;

    always_comb begin
        cfg.en   = (cfg_sel == CFG_SERIAL);
        cfg.len  = LEN_W'(clamp_frame(int'(frame_len), MAX_W));
        cfg.half = DIV_W'(half_of(int'(clk_div)));
        for (int i = 0; i < MAX_W; i++) begin
            word_m[i] = par_in[i] & (i < int'(cfg.len));
        end
    end

    pinred_start_ctl #(.MAX_W(MAX_W)) u_start (
        .clk    (clk),
        .rst    (rst),
        .enable (cfg.en),
        .mode   (start_mode_e'(start_sel)),
        .word   (word_m),
        .trig   (trig_in),
        .idle   (idle),
        .start  (start)
    );

    pinred_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half     (half_q),
        .sck      (sck),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    pinred_shift_core #(.MAX_W(MAX_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .word     (word_m),
        .len      (cfg.len),
        .half_in  (cfg.half),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .sin      (sin),
        .run      (run),
        .idle     (idle),
        .half_q   (half_q),
        .cs_n     (cs_n),
        .sout     (sout),
        .par_out  (par_out)
    );

endmodule

// File: rtl/pinred_master_chk.sv
module pinred_master_chk #(
    parameter  int MAX_W = 16,
    parameter  int DIV_W = 8,
    localparam int LEN_W = $clog2(MAX_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cfg_sel,
    input logic [1:0]       start_sel,
    input logic [LEN_W-1:0] frame_len,
    input logic [DIV_W-1:0] clk_div,
    input logic [MAX_W-1:0] par_in,
    input logic             trig_in,
    input logic             sin,
    input logic             sck,
    input logic             sout,
    input logic             cs_n,
    input logic [MAX_W-1:0] par_out
);

    AST_INACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cs_n && cfg_sel != 2'b01) |=> cs_n); // R2

    AST_FREE_GAP: assert property (@(posedge clk) disable iff (rst)
        ($past($rose(cs_n)) && $past(cfg_sel) == 2'b01 && $past(start_sel) == 2'b00) |-> $fell(cs_n)); // R3

    AST_SOUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n) && !$stable(sout)) |-> $fell(sck)); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) && cs_n) |-> $stable(par_out)); // R8

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck); // R9

endmodule

bind pinred_master pinred_master_chk #(.MAX_W(MAX_W), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_sel   (cfg_sel),
    .start_sel (start_sel),
    .frame_len (frame_len),
    .clk_div   (clk_div),
    .par_in    (par_in),
    .trig_in   (trig_in),
    .sin       (sin),
    .sck       (sck),
    .sout      (sout),
    .cs_n      (cs_n),
    .par_out   (par_out)
);

// File: tb/sim_pinred_master.sv
module sim_pinred_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_sel = 2'b00;
    logic [1:0]  start_sel = 2'b00;
    logic [4:0]  frame_len = 5'd8;
    logic [7:0]  clk_div = 8'd4;
    logic [15:0] par_in = 16'h0;
    logic        trig_in = 1'b0;
    logic        sin = 1'b0;
    logic        sck, sout, cs_n;
    logic [15:0] par_out;

    int          n_chk = 0;
    int          n_bad = 0;
    int          frames = 0;
    int          ends = 0;
    bit          done = 1'b0;
    bit          free_chk = 1'b0;
    logic [15:0] slave_word = 16'h0;

    always #10 clk = ~clk;

    pinred_master u0 (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .start_sel(start_sel),
        .frame_len(frame_len), .clk_div(clk_div), .par_in(par_in),
        .trig_in(trig_in), .sin(sin), .sck(sck), .sout(sout),
        .cs_n(cs_n), .par_out(par_out)
    );

    function automatic int f_len(input int raw);
        if (raw < 4)  return 4;
        if (raw > 16) return 16;
        return raw;
    endfunction

    function automatic int f_half(input int d);
        return (d / 2 < 1) ? 1 : d / 2;
    endfunction

    function automatic logic [15:0] f_mask(input int l);
        logic [31:0] m;
        m = (32'd1 << l) - 32'd1;
        return m[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Far-side device model and frame monitor, sampling 5 ns after each rising edge.
    logic        p_cs = 1'b1, p_sck = 1'b0;
    logic [15:0] m_exp_tx, m_sw, m_rx;
    int          m_len, m_bit, m_nb, m_hc, m_half, m_gap;
    bit          m_prev_free = 1'b0;

    always begin
        @(posedge clk);
        #5;
        if (!rst) begin
            if (p_cs && !cs_n) begin
                frames++;
                if (free_chk && m_prev_free)
                    chk(m_gap == 1, "R3 idle gap", m_gap, 1);
                m_prev_free = 1'b0;
                m_len    = f_len(int'(frame_len));
                m_exp_tx = par_in & f_mask(m_len);
                m_sw     = slave_word;
                m_half   = f_half(int'(clk_div));
                m_bit    = m_len - 1;
                sin      = m_sw[m_bit];
                m_rx     = '0;
                m_nb     = 0;
                m_hc     = 0;
            end else if (!cs_n) begin
                m_hc++;
                if (sck != p_sck) begin
                    chk(m_hc == m_half, "R9 sck level length", m_hc, m_half);
                    m_hc = 0;
                    if (sck) begin
                        m_rx = {m_rx[14:0], sout};
                        m_nb++;
                    end else if (m_bit > 0) begin
                        m_bit--;
                        sin = m_sw[m_bit];
                    end
                end
            end else if (!p_cs && cs_n) begin
                ends++;
                m_hc++;
                chk(m_hc == m_half, "R9 last sck level", m_hc, m_half);
                chk(sck == 1'b0, "R9 sck low at end", sck, 0);
                chk(m_nb == m_len, "R1 bit count", m_nb, m_len);
                chk(m_rx == m_exp_tx, "R7 serial word MSB first", m_rx, m_exp_tx);
                chk(par_out == (m_sw & f_mask(m_len)), "R8 parallel output", par_out, m_sw & f_mask(m_len));
                m_gap = 1;
                m_prev_free = free_chk;
            end else begin
                m_gap++;
            end
        end
        p_cs  = cs_n;
        p_sck = sck;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_end();
        int e0;
        e0 = ends;
        wait (ends == e0 + 1);
        @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic trig_frame(input int l, input int d, input logic [15:0] p, input logic [15:0] s);
        @(negedge clk);
        cfg_sel = 2'b01; start_sel = 2'b10;
        frame_len = 5'(l); clk_div = 8'(d); par_in = p; slave_word = s;
        pulse_trig();
        wait_end();
        tick(2);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int f0;
        void'($urandom(32'd4242));
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(cs_n == 1'b1, "R11 cs_n", cs_n, 1);
        chk(sck == 1'b0, "R11 sck", sck, 0);
        chk(sout == 1'b0, "R11 sout", sout, 0);
        chk(par_out == 16'h0, "R11 par_out", par_out, 0);

        // R2: inactive configurations with free mode and trigger activity
        f0 = frames;
        foreach (cfg_sel[i]) begin end
        cfg_sel = 2'b00; start_sel = 2'b00; tick(20);
        cfg_sel = 2'b10; trig_in = 1'b1; tick(20);
        cfg_sel = 2'b11; trig_in = 1'b0; start_sel = 2'b10; tick(5);
        trig_in = 1'b1; tick(20); trig_in = 1'b0;
        chk(frames == f0, "R2 no frame when inactive", frames, f0);
        chk(cs_n == 1'b1 && sck == 1'b0, "R2 pins idle", {cs_n, sck}, 2'b10);

        // R5 / R7 / R8 directed trigger frame
        f0 = frames;
        trig_frame(8, 4, 16'h12A5, 16'h003C);
        chk(frames == f0 + 1, "R5 single triggered frame", frames, f0 + 1);

        // R5 trigger held high starts one frame
        f0 = frames;
        @(negedge clk); slave_word = 16'h00C3; trig_in = 1'b1;
        tick(80); trig_in = 1'b0; tick(5);
        chk(frames == f0 + 1, "R5 held trigger", frames, f0 + 1);

        // R5 trigger edge during frame ignored
        f0 = frames;
        pulse_trig(); tick(5); pulse_trig();
        tick(60);
        chk(frames == f0 + 1, "R5 trigger during frame", frames, f0 + 1);

        // R1 clamping at both ends and the legal limits
        trig_frame(2, 2, 16'hFFFF, 16'h000A);
        trig_frame(20, 2, 16'h8001, 16'hBEEF);
        trig_frame(16, 2, 16'h7FFE, 16'h1234);
        trig_frame(4, 2, 16'h0009, 16'h0006);

        // R9 divisor rounding
        trig_frame(6, 3, 16'h002D, 16'h0011);
        trig_frame(6, 0, 16'h0012, 16'h002E);
        trig_frame(5, 10, 16'h0015, 16'h000E);

        // R10 input captured at frame start
        @(negedge clk);
        start_sel = 2'b10; frame_len = 5'd8; clk_div = 8'd4;
        par_in = 16'h00A5; slave_word = 16'h005A;
        f0 = frames;
        pulse_trig();
        wait (frames == f0 + 1);
        @(negedge clk); par_in = 16'h00FF;
        wait_end();
        chk(m_exp_tx == 16'h00A5, "R10 captured word", m_exp_tx, 16'h00A5);
        tick(2);

        // R4 change-of-data start
        @(negedge clk);
        frame_len = 5'd8; clk_div = 8'd2; par_in = 16'h0012; slave_word = 16'h0077;
        start_sel = 2'b01;
        f0 = frames;
        tick(40);
        chk(frames == f0 + 1, "R4 change starts frame", frames, f0 + 1);
        tick(40);
        chk(frames == f0 + 1, "R4 stable word no frame", frames, f0 + 1);
        par_in = 16'h0034; tick(40);
        chk(frames == f0 + 2, "R4 new word starts frame", frames, f0 + 2);
        par_in = 16'h0134; tick(40);
        chk(frames == f0 + 2, "R4 change above length ignored", frames, f0 + 2);

        // R6 trigger qualified by change
        @(negedge clk); start_sel = 2'b11;
        f0 = frames;
        pulse_trig(); tick(40);
        chk(frames == f0, "R6 trigger without change", frames, f0);
        par_in = 16'h0056; tick(40);
        chk(frames == f0, "R6 change without trigger", frames, f0);
        pulse_trig(); tick(40);
        chk(frames == f0 + 1, "R6 trigger with change", frames, f0 + 1);

        // R3 free-running frames
        @(negedge clk);
        slave_word = 16'h0099; frame_len = 5'd4; clk_div = 8'd2;
        free_chk = 1'b1; start_sel = 2'b00;
        f0 = ends;
        wait (ends >= f0 + 5);
        @(negedge clk); cfg_sel = 2'b00;
        tick(30);
        free_chk = 1'b0;
        chk(cs_n == 1'b1, "R2 stop after disable", cs_n, 1);

        // Random triggered frames
        for (int k = 0; k < 40; k++) begin
            trig_frame(int'($urandom_range(0, 20)), int'($urandom_range(0, 9)),
                       16'($urandom), 16'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule